// File: doc/BRIEF.md
# Peripheral control registers with a 16-line GPIO port

This block is a small register bank that hangs off a simple valid/write bus. It stores a group of 16-bit control words: mode, card detect, card control, power, three interrupt words and a fixed status word. It also runs a 16-line GPIO port that has a direction register and a level register. The interrupt words are plain storage and raise no interrupt. Software sets the direction mask, then writes levels. Each output line is the level bit gated by its direction bit. External inputs can set or clear level bits directly.

Only the low six address bits are decoded, so the register window repeats every 64 bytes. A read returns its data combinationally in the same cycle as the strobe. The outputs change only when the direction or level register is written. They then move to the new gated value, and only the lines that differ are toggled.

Top module: `gpio_ctrl_regs`

## Requirements
- R1: Only bus_addr[5:0] selects a register, so any address whose low six bits match a register offset reaches that register. Offsets: 0x00 mode, 0x04 card detect, 0x08 status, 0x0C power, 0x10 card control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level-write, 0x28 level-read.
- R2: Each register keeps bus_wdata[15:0], and bus_rdata bits above 15 always read zero.
- R3: A power write whose data has bit 7 set stores the data with bits 15 and 6 also set to 1. Otherwise the power register stores the data unchanged.
- R4: A write to offset 0x24 or 0x28 stores (data AND direction) into the level register.
- R5: After a write to the direction or level register, the next clock edge sets gpio_out to level AND direction.
- R6: A cycle with pin_in_stb[i]=1 sets level bit i to pin_in_val[i], whatever direction bit i holds. gpio_out does not change.
- R7: Reads of 0x24 and 0x28 both return the level register. A read of 0x20 returns the direction register.
- R8: The status register reads 0x0002 after reset, and writes do not change it.
- R9: Reads of any undefined offset (including misaligned ones) return zero. Writes to undefined offsets change no register.
- R10: After reset, every register except status reads zero and gpio_out is all low.
- R11: bus_rdata is valid combinationally in the same cycle as a read strobe, and it is zero when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] are decoded |
| bus_wdata | input | DATA_W | Write data; bits [15:0] are used |
| bus_rdata | output | DATA_W | Read data, zero-extended |
| pin_in_stb | input | 16 | Per-line external level update strobe |
| pin_in_val | input | 16 | Level value applied where the strobe is set |
| gpio_out | output | 16 | Output lines |

## Verification
Several properties are checked on every cycle:
- No output line is ever high while its direction bit is clear.
- Outputs hold steady in any cycle without a direction or level write.
- A level write leaves no level bit set outside the direction mask.
- A power write with bit 7 set forces bits 15 and 6.
- Undefined offsets and the upper read bits read zero.

Some behaviours only the bench scenarios show. These are address aliasing through the upper address bits, read-only status, writes to undefined offsets being ignored, unmasked input events, and reset values. The bench compares every read and every output sample against its own register model under random traffic.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int REG_W   = 16;
  localparam int OFF_W   = 6;
  localparam int PLAIN_N = 6;
  localparam logic [REG_W-1:0] STAT_RST  = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;
  localparam int PWR_TRIG_BIT = 7;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL, SEL_IREQ,
    SEL_IMSK, SEL_ISTAT, SEL_DIR, SEL_LVLW, SEL_LVLR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
    case (off)
      6'h00: return SEL_MODE;
      6'h04: return SEL_CDET;
      6'h08: return SEL_STAT;
      6'h0C: return SEL_PWR;
      6'h10: return SEL_CCTL;
      6'h14: return SEL_IREQ;
      6'h18: return SEL_IMSK;
      6'h1C: return SEL_ISTAT;
      6'h20: return SEL_DIR;
      6'h24: return SEL_LVLW;
      6'h28: return SEL_LVLR;
      default: return SEL_NONE;
    endcase
  endfunction

  // index into the plain storage array, PLAIN_N when not a plain register
  function automatic int plain_index(input reg_sel_e s);
    case (s)
      SEL_MODE:  return 0;
      SEL_CDET:  return 1;
      SEL_CCTL:  return 2;
      SEL_IREQ:  return 3;
      SEL_IMSK:  return 4;
      SEL_ISTAT: return 5;
      default:   return PLAIN_N;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] power_fold(input logic [REG_W-1:0] v);
    return v[PWR_TRIG_BIT] ? (v | PWR_FORCE) : v;
  endfunction

  function automatic logic [REG_W-1:0] level_fold(input logic [REG_W-1:0] v,
                                                  input logic [REG_W-1:0] dir);
    return v & dir;
  endfunction

  function automatic logic [REG_W-1:0] drive_of(input logic [REG_W-1:0] lvl,
                                                input logic [REG_W-1:0] dir);
    return lvl & dir;
  endfunction
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [OFF_W-1:0] off,
  output reg_sel_e         sel,
  output logic             wr_en,
  output logic             rd_en
);
  assign sel   = decode_off(off);
  // status is read-only, undefined offsets take no write
  assign wr_en = bus_valid && bus_write && (sel != SEL_NONE) && (sel != SEL_STAT);
  assign rd_en = bus_valid && !bus_write;
endmodule

// File: rtl/gcr_reg_bank.sv
module gcr_reg_bank
  import gcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] bank_rdata
);
  logic [REG_W-1:0] plain_q [PLAIN_N];
  logic [REG_W-1:0] pwr_q;
  logic             wr_pwr;
  int               wr_idx;

  assign wr_idx = plain_index(sel);
  assign wr_pwr = wr_en && (sel == SEL_PWR);

  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       plain_q[g] <= '0;
      else if (wr_en && wr_idx == g)    plain_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= '0;
    else if (wr_pwr) pwr_q <= power_fold(wdata);
  end

  always_comb begin
    bank_rdata = '0;
    case (sel)
      SEL_STAT: bank_rdata = STAT_RST;
      SEL_PWR:  bank_rdata = pwr_q;
      default:  if (wr_idx < PLAIN_N) bank_rdata = plain_q[wr_idx];
    endcase
  end

  a_r3_power_force: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pwr && wdata[PWR_TRIG_BIT]) |=> (pwr_q[15] && pwr_q[6]));
  a_r3_power_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pwr && !wdata[PWR_TRIG_BIT]) |=> (pwr_q == $past(wdata)));
endmodule

// File: rtl/gcr_gpio_port.sv
module gcr_gpio_port
  import gcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pin_in_stb,
  input  logic [REG_W-1:0] pin_in_val,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] lvl_q,
  output logic [REG_W-1:0] gpio_out
);
  logic             wr_dir, wr_lvl, out_refresh;
  logic [REG_W-1:0] lvl_pins, lvl_d, dir_d, out_q, out_flip;

  assign wr_dir      = wr_en && (sel == SEL_DIR);
  assign wr_lvl      = wr_en && (sel == SEL_LVLW || sel == SEL_LVLR);
  assign out_refresh = wr_dir || wr_lvl;

  // external events act on the level bits without direction gating
  assign lvl_pins = (lvl_q & ~pin_in_stb) | (pin_in_val & pin_in_stb);
  assign lvl_d    = wr_lvl ? level_fold(wdata, dir_q) : lvl_pins;
  assign dir_d    = wr_dir ? wdata : dir_q;
  // lines that must toggle at this edge
  assign out_flip = out_refresh ? (drive_of(lvl_d, dir_d) ^ out_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      out_q <= out_q ^ out_flip;
    end
  end

  assign gpio_out = out_q;

  a_r4_level_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lvl |=> ((lvl_q & ~dir_q) == '0));
  a_r5_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out & ~dir_q) == '0));
  a_r6_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !out_refresh |=> $stable(gpio_out));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [REG_W-1:0]  pin_in_stb,
  input  logic [REG_W-1:0]  pin_in_val,
  output logic [REG_W-1:0]  gpio_out
);
  localparam int HI_W = DATA_W - REG_W;

  reg_sel_e         sel;
  logic             wr_en, rd_en;
  logic [REG_W-1:0] wdata16, bank_rdata, dir_q, lvl_q, rd16;
  logic             unused_hi;

  assign wdata16   = bus_wdata[REG_W-1:0];
  assign unused_hi = ^{bus_addr[ADDR_W-1:OFF_W], bus_wdata[DATA_W-1:REG_W]};

  gcr_decode u_decode (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .off       (bus_addr[OFF_W-1:0]),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en)
  );

  gcr_reg_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sel        (sel),
    .wdata      (wdata16),
    .bank_rdata (bank_rdata)
  );

  gcr_gpio_port u_gpio (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sel        (sel),
    .wdata      (wdata16),
    .pin_in_stb (pin_in_stb),
    .pin_in_val (pin_in_val),
    .dir_q      (dir_q),
    .lvl_q      (lvl_q),
    .gpio_out   (gpio_out)
  );

  always_comb begin
    case (sel)
      SEL_DIR:            rd16 = dir_q;
      SEL_LVLW, SEL_LVLR: rd16 = lvl_q;
      default:            rd16 = bank_rdata;
    endcase
  end

  assign bus_rdata = rd_en ? {{HI_W{1'b0}}, rd16} : '0;

  a_r9_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |-> (bus_rdata == '0));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata >> REG_W) == '0));
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_ctrl_regs_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in_stb = '0, pin_in_val = '0;
  logic [15:0] gpio_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_plain [6];
  logic [15:0] m_pwr, m_dir, m_lvl, m_out;

  always #4 clk = ~clk;

  gpio_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in_stb(pin_in_stb), .pin_in_val(pin_in_val), .gpio_out(gpio_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int plain_slot(input logic [5:0] off);
    int s;
    s = -1;
    if (off == 6'h00) s = 0;
    if (off == 6'h04) s = 1;
    if (off == 6'h10) s = 2;
    if (off == 6'h14) s = 3;
    if (off == 6'h18) s = 4;
    if (off == 6'h1C) s = 5;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] off);
    int s;
    s = plain_slot(off);
    if (s >= 0) return {16'h0, m_plain[s]};
    if (off == 6'h08) return 32'h2;
    if (off == 6'h0C) return {16'h0, m_pwr};
    if (off == 6'h20) return {16'h0, m_dir};
    if (off == 6'h24 || off == 6'h28) return {16'h0, m_lvl};
    return 32'h0;
  endfunction

  function automatic logic [15:0] pwr_rule(input logic [15:0] d);
    logic [15:0] r;
    r = d;
    if (d[7]) begin r[15] = 1'b1; r[6] = 1'b1; end
    return r;
  endfunction

  task automatic model_write(input logic [5:0] off, input logic [31:0] d);
    int s;
    s = plain_slot(off);
    if (s >= 0) m_plain[s] = d[15:0];
    else if (off == 6'h0C) m_pwr = pwr_rule(d[15:0]);
    else if (off == 6'h20) begin m_dir = d[15:0]; m_out = m_lvl & m_dir; end
    else if (off == 6'h24 || off == 6'h28) begin
      m_lvl = d[15:0] & m_dir; m_out = m_lvl & m_dir;
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    model_write(a[5:0], d);
  endtask

  task automatic bus_rd(input string req, input logic [11:0] a);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp_read(a[5:0]));
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pin_event(input logic [15:0] s, input logic [15:0] v);
    @(negedge clk);
    pin_in_stb = s; pin_in_val = v;
    @(negedge clk);
    pin_in_stb = '0;
    m_lvl = (m_lvl & ~s) | (v & s);
    check("R6 outputs unchanged by pin event", {16'h0, gpio_out}, {16'h0, m_out});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 6; i++) m_plain[i] = '0;
    m_pwr = '0; m_dir = '0; m_lvl = '0; m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 / R8 reset values
    check("R10 outputs low after reset", {16'h0, gpio_out}, 32'h0);
    for (int k = 0; k < 11; k++) bus_rd("R10 R8 reset read", 12'(k * 4));
    check("R11 idle rdata zero", bus_rdata, 32'h0);

    // R8 status read-only
    bus_wr(12'h008, 32'hFFFF);
    bus_rd("R8 status read-only", 12'h008);

    // R3 power side effect
    bus_wr(12'h00C, 32'h0080);
    bus_rd("R3 power bit7 forces 15 and 6", 12'h00C);
    check("R3 power literal", {16'h0, m_pwr}, 32'h80C0);
    bus_wr(12'h00C, 32'h0041);
    bus_rd("R3 power without bit7", 12'h00C);

    // R2 upper write bits dropped
    bus_wr(12'h000, 32'hABCD_1234);
    bus_rd("R2 upper bits dropped", 12'h000);

    // R1 alias through upper address bits
    bus_wr(12'hFD0, 32'h5A5A);
    bus_rd("R1 alias read", 12'h010);

    // R4 / R5: level masked, outputs gated
    bus_wr(12'h024, 32'hFFFF);
    check("R5 no outputs with dir zero", {16'h0, gpio_out}, 32'h0);
    bus_rd("R4 level masked by zero dir", 12'h028);
    bus_wr(12'h020, 32'h00F0);
    bus_wr(12'h028, 32'h0FFF);
    bus_rd("R7 level via 0x24", 12'h024);
    bus_rd("R7 level via 0x28", 12'h028);
    bus_rd("R7 dir read", 12'h020);
    check("R5 outputs gated", {16'h0, gpio_out}, 32'h00F0);

    // R6 pin events unmasked, no output change
    pin_event(16'hF00F, 16'hF001);
    bus_rd("R6 pin event sets unmasked level", 12'h024);
    bus_wr(12'h020, 32'hFFFF);
    check("R5 dir write exposes pin-set level", {16'h0, gpio_out}, {16'h0, m_lvl});

    // R9 undefined offsets
    bus_wr(12'h02C, 32'hFFFF);
    bus_wr(12'h03C, 32'hFFFF);
    bus_wr(12'h002, 32'hFFFF);
    bus_rd("R9 undefined read zero", 12'h030);
    bus_rd("R9 misaligned read zero", 12'h006);
    for (int k = 0; k < 11; k++) bus_rd("R9 undefined write ignored", 12'(k * 4));

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r, d;
      logic [11:0] a;
      r = $urandom;
      d = $urandom;
      a = {6'(r[31:26]), (r[3] ? 6'(r[7:4] * 4) : 6'(r[13:8]))};
      case (r[1:0])
        2'd0, 2'd1: begin
          bus_wr(a, d);
          check("R5 random output", {16'h0, gpio_out}, {16'h0, m_out});
        end
        2'd2: bus_rd("R1 R7 R9 random read", a);
        default: pin_event(d[15:0], d[31:16]);
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule